// File: doc/BRIEF.md
# Transposed-Form FIR Filter with Upper-Nibble Products

This block is a four-tap finite impulse response filter for unsigned 4-bit samples and unsigned 4-bit coefficients. It uses the transposed structure. Each accepted sample goes to every tap at once. Each tap forms the product of the sample and its own coefficient, and keeps only the high nibble of the 8-bit result. That nibble is added to the partial sum that the next tap along the chain registered on the previous accepted sample.

Each multiplier is built from four 2x2 sub-multipliers and three 4-bit ripple adders. Every adder in the block starts with a half adder at bit 0, followed by full adders. Partial sums stay 4 bits wide, so a carry out of any adder is dropped from the sum. A carry of that kind raises an overflow flag, which travels down the chain with the partial sum it belongs to. The output register and the delay registers advance only on cycles where the sample strobe is high. A small two-state machine marks each fresh result for exactly one cycle.

Top module: `fir_tdf_top`

## Requirements
- R1: Synchronous reset (`rst` high at a clock edge) clears `sum_out`, `sum_ovf`, `sum_valid` and every delay register to zero. The first result after reset therefore contains only the taps that have seen a sample since reset.
- R2: `sum_valid` is high in the cycle after each clock edge where `in_valid` was high, and low after every edge where `in_valid` was low. The output state machine has two states. It moves from OUT_IDLE to OUT_SHOW on an accepted sample, from OUT_SHOW to OUT_SHOW on another accepted sample, and from either state to OUT_IDLE when no sample arrives.
- R3: For accepted samples x[n], x[n-1], ... (zero before reset), `sum_out` equals the sum over k = 0..3 of t(h[k], x[n-k]), taken modulo 16.
- R4: The tap term is t(h, x) = floor(h·x / 16), which is the upper nibble of the 8-bit product. The lower nibble never reaches the sum. For example, t(15, 15) = 14 and t(1, 15) = 0.
- R5: When `in_valid` is low, `sum_out`, `sum_ovf` and the delay state hold, whatever `sample_in` carries.
- R6: `sum_ovf` is high exactly when the unwrapped sum of the four tap terms for that result exceeds 15. This is the same as any adder on that result's path producing a carry-out.
- R7: The coefficient for delay k sits at bits [4k+3:4k] of `coef_flat`. h[0] weights the current sample, and h[3] weights the sample three accepted samples earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample strobe; the chain advances when high |
| sample_in | input | 4 | Unsigned input sample |
| coef_flat | input | 16 | Four unsigned 4-bit coefficients, h[k] at bits [4k+3:4k] |
| sum_out | output | 4 | Filter result, wrapped to 4 bits |
| sum_valid | output | 1 | High for one cycle after each accepted sample |
| sum_ovf | output | 1 | A carry was dropped while forming this result |

## Verification
The bench builds the filter with its default widths and four taps. At that size every coefficient set, every impulse position and the full overflow range (tap sums from 0 up to 56) are small enough to check against an arithmetic reference model.

The coefficient sets are chosen to exercise several behaviours:
- All-zero and all-maximum sets drive the sum to its lowest value and to repeated wrapping.
- An impulse exposes each coefficient position separately.
- Unit coefficients against a full-scale sample show the truncation.

Idle cycles with a changing sample bus, together with reset in the middle of a stream, cover the hold and the partial-fill behaviour.

// File: rtl/fir_tdf_pkg.sv
package fir_tdf_pkg;
    localparam int SAMPLE_W = 4;
    localparam int HALF_W   = SAMPLE_W / 2;
    localparam int PROD_W   = 2 * SAMPLE_W;

    typedef logic [SAMPLE_W-1:0] nib_t;

    typedef enum logic {
        OUT_IDLE = 1'b0,
        OUT_SHOW = 1'b1
    } out_state_e;
endpackage

// File: rtl/fir_add_ripple.sv
// Ripple-carry adder: half adder at bit 0, full adders above it.
module fir_add_ripple #(
    parameter int W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] s,
    output logic         co
);
    logic [W:0] c;

    assign c[0] = 1'b0;

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (i == 0) begin : g_half
            assign s[i]   = a[i] ^ b[i];
            assign c[i+1] = a[i] & b[i];
        end else begin : g_full
            assign s[i]   = a[i] ^ b[i] ^ c[i];
            assign c[i+1] = (a[i] & b[i]) | (a[i] & c[i]) | (b[i] & c[i]);
        end
    end

    assign co = c[W];
endmodule

// File: rtl/fir_mul2x2.sv
// 2x2 multiplier built from AND terms and two half adders.
module fir_mul2x2 (
    input  logic [1:0] a,
    input  logic [1:0] b,
    output logic [3:0] p
);
    logic cross_c;
    logic hi_term;

    assign p[0]    = a[0] & b[0];
    assign p[1]    = (a[1] & b[0]) ^ (a[0] & b[1]);
    assign cross_c = (a[1] & b[0]) & (a[0] & b[1]);
    assign hi_term = a[1] & b[1];
    assign p[2]    = hi_term ^ cross_c;
    assign p[3]    = hi_term & cross_c;
endmodule

// File: rtl/fir_mul4x4.sv
// 4x4 multiplier assembled from four 2x2 blocks and three ripple adders.
module fir_mul4x4
    import fir_tdf_pkg::*;
(
    input  nib_t              a,
    input  nib_t              b,
    output logic [PROD_W-1:0] p
);
    // q[2*ia+ib] is the product of nibble half ia of a and half ib of b.
    logic [3:0] q [4];

    for (genvar ia = 0; ia < 2; ia++) begin : g_row
        for (genvar ib = 0; ib < 2; ib++) begin : g_col
            fir_mul2x2 u_m (
                .a(a[ia*HALF_W +: HALF_W]),
                .b(b[ib*HALF_W +: HALF_W]),
                .p(q[2*ia+ib])
            );
        end
    end

    logic [3:0] mid_s;
    logic [3:0] mid2_s;
    logic [3:0] top_s;
    logic       mid_c;
    logic       mid2_c;
    logic       top_c_unused;

    // The two cross products, which share the same weight.
    fir_add_ripple #(.W(4)) u_add_mid (
        .a(q[1]), .b(q[2]), .s(mid_s), .co(mid_c)
    );

    // Add the upper half of the low-by-low product.
    fir_add_ripple #(.W(4)) u_add_mid2 (
        .a(mid_s), .b({2'b00, q[0][3:2]}), .s(mid2_s), .co(mid2_c)
    );

    // The high-by-high product plus the carried middle bits.
    // At most one of mid_c and mid2_c can be set.
    fir_add_ripple #(.W(4)) u_add_top (
        .a(q[3]), .b({1'b0, mid_c | mid2_c, mid2_s[3:2]}),
        .s(top_s), .co(top_c_unused)
    );

    assign p = {top_s, mid2_s[1:0], q[0][1:0]};
endmodule

// File: rtl/fir_tap.sv
// One tap: upper product nibble plus the incoming partial sum.
module fir_tap
    import fir_tdf_pkg::*;
(
    input  nib_t coef,
    input  nib_t x,
    input  nib_t z_in,
    input  logic ovf_in,
    output nib_t sum,
    output logic ovf
);
    logic [PROD_W-1:0] prod;
    nib_t              prod_hi;
    nib_t              prod_lo_unused;
    logic              carry;

    fir_mul4x4 u_mul (
        .a(coef), .b(x), .p(prod)
    );

    assign {prod_hi, prod_lo_unused} = prod;

    fir_add_ripple #(.W(SAMPLE_W)) u_acc (
        .a(prod_hi), .b(z_in), .s(sum), .co(carry)
    );

    assign ovf = carry | ovf_in;
endmodule

// File: rtl/fir_tdf_top.sv
module fir_tdf_top
    import fir_tdf_pkg::*;
#(
    parameter int TAPS = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic [SAMPLE_W-1:0]      sample_in,
    input  logic [TAPS*SAMPLE_W-1:0] coef_flat,
    output logic [SAMPLE_W-1:0]      sum_out,
    output logic                     sum_valid,
    output logic                     sum_ovf
);
    localparam int NDLY = TAPS - 1;

    nib_t t_sum   [TAPS];
    logic t_ovf   [TAPS];
    nib_t t_zin   [TAPS];
    logic t_oin   [TAPS];
    nib_t z_q     [NDLY];
    logic zovf_q  [NDLY];
    nib_t sum_q;
    logic ovf_q;

    out_state_e state_q;
    out_state_e state_d;

    for (genvar k = 0; k < TAPS; k++) begin : g_tap
        if (k == TAPS - 1) begin : g_last
            assign t_zin[k] = '0;
            assign t_oin[k] = 1'b0;
        end else begin : g_mid
            assign t_zin[k] = z_q[k];
            assign t_oin[k] = zovf_q[k];
        end

        fir_tap u_tap (
            .coef  (coef_flat[k*SAMPLE_W +: SAMPLE_W]),
            .x     (sample_in),
            .z_in  (t_zin[k]),
            .ovf_in(t_oin[k]),
            .sum   (t_sum[k]),
            .ovf   (t_ovf[k])
        );
    end

    // Delay chain and output register advance only on accepted samples.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < NDLY; k++) begin
                z_q[k]    <= '0;
                zovf_q[k] <= 1'b0;
            end
            sum_q <= '0;
            ovf_q <= 1'b0;
        end else if (in_valid) begin
            for (int k = 1; k < TAPS; k++) begin
                z_q[k-1]    <= t_sum[k];
                zovf_q[k-1] <= t_ovf[k];
            end
            sum_q <= t_sum[0];
            ovf_q <= t_ovf[0];
        end
    end

    // Output state register.
    always_ff @(posedge clk) begin
        if (rst) state_q <= OUT_IDLE;
        else     state_q <= state_d;
    end

    // Next-state decision.
    always_comb begin
        state_d = OUT_IDLE;
        unique case (state_q)
            OUT_IDLE: state_d = in_valid ? OUT_SHOW : OUT_IDLE;
            OUT_SHOW: state_d = in_valid ? OUT_SHOW : OUT_IDLE;
            default:  state_d = OUT_IDLE;
        endcase
    end

    // Outputs.
    always_comb begin
        sum_valid = 1'b0;
        unique case (state_q)
            OUT_IDLE: sum_valid = 1'b0;
            OUT_SHOW: sum_valid = 1'b1;
            default:  sum_valid = 1'b0;
        endcase
        sum_out = sum_q;
        sum_ovf = ovf_q;
    end
endmodule

// File: rtl/fir_tdf_chk.sv
module fir_tdf_chk (
    input logic       clk,
    input logic       rst,
    input logic       in_valid,
    input logic [3:0] sample_in,
    input logic [3:0] coef0,
    input logic [3:0] sum_out,
    input logic       sum_valid,
    input logic       sum_ovf
);
    logic [7:0] full_prod;
    logic [3:0] first_term;

    assign full_prod  = {4'b0, coef0} * {4'b0, sample_in};
    assign first_term = full_prod[7:4];

    // R1: reset clears the outputs.
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (!sum_valid && sum_out == 4'd0 && !sum_ovf));

    // R2: an accepted sample raises valid on the next cycle.
    a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> sum_valid);

    // R2: no sample means no valid on the next cycle.
    a_r2_idle_no_valid: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !sum_valid);

    // R5: outputs hold while no sample is accepted.
    a_r5_hold: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(sum_out) && $stable(sum_ovf)));

    // R3/R4: the first sample after reset yields only the truncated tap-0 term.
    a_r3_first_only_tap0: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && in_valid) |=> (sum_out == $past(first_term) && !sum_ovf));
endmodule

bind fir_tdf_top fir_tdf_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .sample_in(sample_in),
    .coef0    (coef_flat[3:0]),
    .sum_out  (sum_out),
    .sum_valid(sum_valid),
    .sum_ovf  (sum_ovf)
);

// File: tb/fir_tdf_top_test.sv
module fir_tdf_top_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [3:0]  sample_in = 4'd0;
    logic [15:0] coef_flat = 16'd0;
    logic [3:0]  sum_out;
    logic        sum_valid;
    logic        sum_ovf;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    fir_tdf_top uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .sample_in(sample_in),
        .coef_flat(coef_flat), .sum_out(sum_out), .sum_valid(sum_valid),
        .sum_ovf(sum_ovf)
    );

    // Stimulus table: {coefficients, six samples fed oldest first}.
    localparam int NVEC = 6;
    localparam logic [39:0] VEC [NVEC] = '{
        40'h0000_9ABCDE,
        40'hFFFF_FFFFFF,
        40'h1234_5A3C69,
        40'h8F07_F0F0F0,
        40'hC3A5_7E2B94,
        40'h0F00_4D8EF1
    };

    // Reference model state.
    int  hist [4];
    bit  pend;
    int  exp_sum;
    bit  exp_ovf;

    function automatic int term(input int h, input int x);
        return (h * x) / 16;
    endfunction

    task automatic chk(input string tag, input int act, input int exp_v, input string what);
        total++;
        if (act != exp_v) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp_v);
        end
    endtask

    task automatic model_clear();
        for (int k = 0; k < 4; k++) hist[k] = 0;
        pend = 1'b0;
        exp_sum = 0;
        exp_ovf = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_clear();
        chk("R1", sum_valid, 0, "valid after reset");
        chk("R1", sum_out, 0, "sum after reset");
        chk("R1", sum_ovf, 0, "ovf after reset");
    endtask

    // Called at a negedge: check the previous cycle's result, then drive new inputs.
    task automatic feed(input bit v, input logic [3:0] x);
        int acc;
        @(negedge clk);
        if (pend) begin
            chk("R2", sum_valid, 1, "valid after sample");
            chk("R3", sum_out, exp_sum, "sum");
            chk("R6", sum_ovf, exp_ovf, "ovf");
        end else begin
            chk("R2", sum_valid, 0, "valid when idle");
            chk("R5", sum_out, exp_sum, "held sum");
            chk("R5", sum_ovf, exp_ovf, "held ovf");
        end
        in_valid  = v;
        sample_in = x;
        pend = v;
        if (v) begin
            for (int k = 3; k > 0; k--) hist[k] = hist[k-1];
            hist[0] = int'(x);
            acc = 0;
            for (int k = 0; k < 4; k++)
                acc += term(int'(coef_flat[4*k +: 4]), hist[k]);
            exp_sum = acc % 16;
            exp_ovf = (acc > 15);
        end
    endtask

    initial begin
        do_reset();

        // Table walk: R3, R6, R7 across several coefficient sets.
        for (int i = 0; i < NVEC; i++) begin
            coef_flat = VEC[i][39:24];
            do_reset();
            for (int j = 0; j < 6; j++)
                feed(1'b1, VEC[i][23 - 4*j -: 4]);
            feed(1'b0, 4'd0);
        end

        // R6: all maximum, hand values 14, 12/ovf, 10/ovf, 8/ovf.
        coef_flat = 16'hFFFF;
        do_reset();
        feed(1'b1, 4'hF);
        feed(1'b1, 4'hF); chk("R6", sum_out, 14, "max n0"); chk("R6", sum_ovf, 0, "max n0 ovf");
        feed(1'b1, 4'hF); chk("R6", sum_out, 12, "max n1"); chk("R6", sum_ovf, 1, "max n1 ovf");
        feed(1'b1, 4'hF); chk("R6", sum_out, 10, "max n2");
        feed(1'b0, 4'h0); chk("R6", sum_out, 8,  "max n3"); chk("R6", sum_ovf, 1, "max n3 ovf");

        // R7: impulse through h = {9, A, 5, F} gives 14, 4, 9, 8.
        coef_flat = 16'h9A5F;
        do_reset();
        feed(1'b1, 4'hF);
        feed(1'b1, 4'h0); chk("R7", sum_out, 14, "impulse k0");
        feed(1'b1, 4'h0); chk("R7", sum_out, 4,  "impulse k1");
        feed(1'b1, 4'h0); chk("R7", sum_out, 9,  "impulse k2");
        feed(1'b0, 4'h0); chk("R7", sum_out, 8,  "impulse k3");

        // R4: unit coefficients against full scale truncate to zero.
        coef_flat = 16'h1111;
        do_reset();
        for (int j = 0; j < 4; j++) feed(1'b1, 4'hF);
        feed(1'b0, 4'h0);
        chk("R4", sum_out, 0, "unit coef truncation");

        // R5: idle cycles with a moving sample bus, then resume.
        coef_flat = 16'h7BD3;
        do_reset();
        feed(1'b1, 4'hC);
        feed(1'b1, 4'h9);
        for (int j = 0; j < 5; j++) feed(1'b0, 4'(j * 3 + 1));
        feed(1'b1, 4'hE);
        feed(1'b1, 4'h6);
        feed(1'b0, 4'hF);

        // R1: reset in mid-stream, then only tap 0 contributes.
        feed(1'b1, 4'hA);
        feed(1'b1, 4'hB);
        do_reset();
        feed(1'b1, 4'hD);
        feed(1'b0, 4'h0);
        chk("R1", sum_out, term(3, 13), "first after mid reset");
        feed(1'b0, 4'h0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule